// File: doc/BRIEF.md
# Core Power Sequencer

This block powers individual processor cores up and down in a fixed, safe order. A cluster holds up to four cores. Software asks for one of them to be switched on or off by giving a core index and a direction. The sequencer then works through that core's control outputs one step at a time:

- the two-bit core reset field
- the L1 reset-disable bit
- the debug power-up indication
- the staged 8-bit power-switch code
- the power-off gating bit

Between steps it waits a fixed number of microseconds. These delays come from a prescaler set in clock cycles per microsecond.

When a switch ramp ends, the sequencer stalls until the switch acknowledge readback for that core equals the code it commanded. Only then does it go on. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end. Each core's wait-for-interrupt status is taken from its status word and passed out as a flag.

Top module: `core_power_sequencer`

## Requirements
- R1: After reset, every core has reset field 0, L1 reset-disable 1, debug power-up 0, switch code 0xFF and gating 1. Busy and done are both 0.
- R2: A power-up request is accepted at a clock edge. At the next edge the core's reset field goes to 0 and its L1 reset-disable bit is cleared. After 10 us (10*CYC_PER_US+1 cycles) its debug power-up bit is cleared.
- R3: One cycle after that, the switch code (bits [8i+7:8i] of sw_code) steps through 0xFE, 0xF8, 0xE0, 0x80 and 0x00. The dwells after these codes are 20, 10, 10, 10 and 20 us, and a dwell of d us separates code changes by d*CYC_PER_US+1 cycles.
- R4: After the last dwell of power-up, the sequencer waits until the core's acknowledge byte equals 0x00. The gating bit is cleared two cycles after the match is first seen at an edge, or 20*CYC_PER_US+2 cycles after code 0x00 if the acknowledge already matches. After a further 20 us the reset field (bits [2i+1:2i]) becomes 3, and one cycle later debug power-up becomes 1.
- R5: A power-down request is handled in this order, one cycle apart: reset field to 0, debug power-up to 0, gating to 1. After 20 us the switch code becomes 0xFF.
- R6: After the switch code 0xFF, the sequencer waits 30 us and then for the acknowledge byte to equal 0xFF. Done follows one edge after the match.
- R7: A request is ignored if it arrives while busy or if its core index is greater than cfg_cores. In both cases no output of any core changes.
- R8: A request that would leave the core where it already is (req_up=1 for a core that is on, 0 for a core that is off) makes done pulse at the next edge. Busy stays 0 and no output changes.
- R9: wfi[i] equals bit 2 of core i's status word core_stat[i*STAT_W +: STAT_W].
- R10: Busy is 1 from the edge that accepts a request until the edge of the last step. Done is a one-cycle pulse on that last edge.
- R11: A sequence changes only the outputs of the core it was asked for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cores | input | 2 | Populated core count minus one |
| req_valid | input | 1 | Request strobe |
| req_up | input | 1 | 1 = power up, 0 = power down |
| req_core | input | 2 | Target core index |
| sw_ack | input | 32 | Switch readback, byte i for core i |
| core_stat | input | 4*STAT_W | Per-core status words |
| core_rst | output | 8 | Reset field, 2 bits per core (3 = released) |
| l1_rst_dis | output | 4 | L1 reset-disable, one per core |
| dbg_pwrup | output | 4 | Debug power-up indication, one per core |
| sw_code | output | 32 | Power-switch code, byte i for core i |
| pwroff_gate | output | 4 | Power-off gating, one per core |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| wfi | output | 4 | Per-core wait-for-interrupt flag |

## Verification
A new request can land in the same cycle as a step of a running sequence. The bench makes this happen by firing a second request at a random core in the middle of many sequences. It is judged correct when that core's outputs stay unchanged and the running sequence keeps its exact step times. The acknowledge readback can also arrive in the very cycle the wait for acknowledge begins. The bench holds the readback back and releases it one or more cycles after that point, and checks that gating, or done, follows by the fixed number of edges.

// File: rtl/core_power_sequencer.sv
module core_power_sequencer #(
  parameter int CYC_PER_US = 50,
  parameter int NCORE      = 4,
  parameter int STAT_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_cores,
  input  logic                     req_valid,
  input  logic                     req_up,
  input  logic [1:0]               req_core,
  input  logic [NCORE*8-1:0]       sw_ack,
  input  logic [NCORE*STAT_W-1:0]  core_stat,
  output logic [NCORE*2-1:0]       core_rst,
  output logic [NCORE-1:0]         l1_rst_dis,
  output logic [NCORE-1:0]         dbg_pwrup,
  output logic [NCORE*8-1:0]       sw_code,
  output logic [NCORE-1:0]         pwroff_gate,
  output logic                     busy,
  output logic                     done,
  output logic [NCORE-1:0]         wfi
);
  localparam int US_W  = 5;
  localparam int PRE_W = $clog2(CYC_PER_US + 1);
  localparam logic [PRE_W-1:0] PRE_LD = PRE_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  US10 = 5'd10;
  localparam logic [US_W-1:0]  US20 = 5'd20;
  localparam logic [US_W-1:0]  US30 = 5'd30;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT, U_RST, U_DBG0, U_SW, U_ACK, U_GATE, U_REL, U_DBG1,
    D_RST, D_DBG, D_GATE, D_SW, D_ACK
  } st_t;

  st_t              st, ret;
  logic [2:0]       idx;
  logic [1:0]       core;
  logic [PRE_W-1:0] pre;
  logic [US_W-1:0]  us;
  logic [NCORE-1:0] on;
  logic [7:0]       ack_sel;

  function automatic logic [7:0] ramp_code(input logic [2:0] k);
    case (k)
      3'd0:    return 8'hFE;
      3'd1:    return 8'hF8;
      3'd2:    return 8'hE0;
      3'd3:    return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [US_W-1:0] ramp_dwell(input logic [2:0] k);
    case (k)
      3'd0, 3'd4: return US20;
      default:    return US10;
    endcase
  endfunction

  assign busy    = (st != S_IDLE);
  assign ack_sel = sw_ack[{core, 3'b000} +: 8];

  for (genvar i = 0; i < NCORE; i++) begin : g_wfi
    assign wfi[i] = core_stat[i*STAT_W + 2];
  end
  logic unused_stat;
  assign unused_stat = ^core_stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ret         <= S_IDLE;
      idx         <= '0;
      core        <= '0;
      pre         <= '0;
      us          <= '0;
      on          <= '0;
      done        <= 1'b0;
      core_rst    <= '0;
      l1_rst_dis  <= '1;
      dbg_pwrup   <= '0;
      sw_code     <= '1;
      pwroff_gate <= '1;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (req_valid && req_core <= cfg_cores) begin
          core <= req_core;
          if (req_up == on[req_core]) done <= 1'b1;
          else st <= req_up ? U_RST : D_RST;
        end
        S_WAIT: begin
          if (pre == '0) begin
            if (us == US_W'(1)) st <= ret;
            else begin
              us  <= us - US_W'(1);
              pre <= PRE_LD;
            end
          end else pre <= pre - PRE_W'(1);
        end
        U_RST: begin
          core_rst[{core, 1'b0} +: 2] <= 2'b00;
          l1_rst_dis[core] <= 1'b0;
          st <= S_WAIT; ret <= U_DBG0; us <= US10; pre <= PRE_LD;
        end
        U_DBG0: begin
          dbg_pwrup[core] <= 1'b0;
          idx <= '0;
          st  <= U_SW;
        end
        U_SW: begin
          sw_code[{core, 3'b000} +: 8] <= ramp_code(idx);
          st  <= S_WAIT;
          ret <= (idx == 3'd4) ? U_ACK : U_SW;
          us  <= ramp_dwell(idx);
          pre <= PRE_LD;
          idx <= idx + 3'd1;
        end
        U_ACK: if (ack_sel == 8'h00) st <= U_GATE;
        U_GATE: begin
          pwroff_gate[core] <= 1'b0;
          st <= S_WAIT; ret <= U_REL; us <= US20; pre <= PRE_LD;
        end
        U_REL: begin
          core_rst[{core, 1'b0} +: 2] <= 2'b11;
          st <= U_DBG1;
        end
        U_DBG1: begin
          dbg_pwrup[core] <= 1'b1;
          on[core] <= 1'b1;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        D_RST: begin
          core_rst[{core, 1'b0} +: 2] <= 2'b00;
          st <= D_DBG;
        end
        D_DBG: begin
          dbg_pwrup[core] <= 1'b0;
          st <= D_GATE;
        end
        D_GATE: begin
          pwroff_gate[core] <= 1'b1;
          st <= S_WAIT; ret <= D_SW; us <= US20; pre <= PRE_LD;
        end
        D_SW: begin
          sw_code[{core, 3'b000} +: 8] <= 8'hFF;
          st <= S_WAIT; ret <= D_ACK; us <= US30; pre <= PRE_LD;
        end
        D_ACK: if (ack_sel == 8'hFF) begin
          on[core] <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module core_power_sequencer_chk #(
  parameter int NCORE = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         cfg_cores,
  input logic               req_valid,
  input logic [1:0]         req_core,
  input logic [NCORE*8-1:0] sw_ack,
  input logic [NCORE*2-1:0] core_rst,
  input logic [NCORE-1:0]   l1_rst_dis,
  input logic [NCORE-1:0]   dbg_pwrup,
  input logic [NCORE*8-1:0] sw_code,
  input logic [NCORE-1:0]   pwroff_gate,
  input logic               busy,
  input logic               done
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    p_dbg_after_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $rose(dbg_pwrup[i]) |-> core_rst[2*i +: 2] == 2'b11);
    p_gate_open_after_ramp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $fell(pwroff_gate[i]) |-> sw_code[8*i +: 8] == 8'h00 && sw_ack[8*i +: 8] == 8'h00);
    p_release_needs_power_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $rose(&core_rst[2*i +: 2]) |-> !pwroff_gate[i] && !dbg_pwrup[i]);
    p_switch_off_after_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seen && $rose(sw_code[8*i +: 8] == 8'hFF) |-> pwroff_gate[i] && core_rst[2*i +: 2] == 2'b00);
  end

  p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seen && !busy |=> $stable(sw_code) && $stable(core_rst) && $stable(pwroff_gate)
                      && $stable(dbg_pwrup) && $stable(l1_rst_dis));
  p_bad_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && req_valid && req_core > cfg_cores |=> !busy && !done);
  p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind core_power_sequencer core_power_sequencer_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cores(cfg_cores), .req_valid(req_valid),
  .req_core(req_core), .sw_ack(sw_ack), .core_rst(core_rst),
  .l1_rst_dis(l1_rst_dis), .dbg_pwrup(dbg_pwrup), .sw_code(sw_code),
  .pwroff_gate(pwroff_gate), .busy(busy), .done(done)
);

// File: tb/sim_core_power_sequencer.sv
module sim_core_power_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int C  = 2;
  localparam int N  = 4;
  localparam int SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cfg_cores = 2'd3;
  logic req_valid = 1'b0, req_up = 1'b0;
  logic [1:0] req_core = '0;
  logic [N*8-1:0] sw_ack = '1;
  logic [N*SW-1:0] core_stat = '0;
  logic [N*2-1:0] core_rst;
  logic [N-1:0] l1_rst_dis, dbg_pwrup, pwroff_gate, wfi;
  logic [N*8-1:0] sw_code;
  logic busy, done;

  core_power_sequencer #(.CYC_PER_US(C), .NCORE(N), .STAT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cores(cfg_cores), .req_valid(req_valid),
    .req_up(req_up), .req_core(req_core), .sw_ack(sw_ack), .core_stat(core_stat),
    .core_rst(core_rst), .l1_rst_dis(l1_rst_dis), .dbg_pwrup(dbg_pwrup),
    .sw_code(sw_code), .pwroff_gate(pwroff_gate), .busy(busy), .done(done), .wfi(wfi));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit fin = 0;
  bit hold = 0;
  int hc = 0;
  logic [12:0] mv[N];
  bit mon[N];

  // vector: [12:11] reset field, [10] L1 disable, [9] debug, [8:1] switch, [0] gating
  function automatic logic [12:0] vec_of(input int c);
    return {core_rst[2*c +: 2], l1_rst_dis[c], dbg_pwrup[c], sw_code[8*c +: 8], pwroff_gate[c]};
  endfunction

  function automatic logic [7:0] exp_code(input int k);
    case (k) 0: return 8'hFE; 1: return 8'hF8; 2: return 8'hE0; 3: return 8'h80; default: return 8'h00; endcase
  endfunction

  function automatic int exp_dwell(input int k);
    return (k == 0 || k == 4) ? 20 : 10;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    logic [SW-1:0] w;
    @(negedge clk);
    for (int c = 0; c < N; c++)
      if (!(hold && c == hc)) sw_ack[8*c +: 8] = sw_code[8*c +: 8];
    core_stat = N*SW'($urandom);
    #1;
    for (int c = 0; c < N; c++) begin
      w = core_stat[c*SW +: SW];
      chk(wfi[c] == w[2], "R9", "wfi flag", 32'(wfi[c]), 32'(w[2]));
    end
  endtask

  task automatic run(input int c, input bit up, input bit stall, input int extra, input bit spur);
    int at_t[16]; logic [12:0] at_v[16]; string at_r[16];
    int n = 0, t = 0, done_t, tr = -1, s;
    logic [12:0] v = mv[c], cur;
    string rq;
    if (up == mon[c]) done_t = 1;
    else if (up) begin
      t = 2; v[12:11] = 2'b00; v[10] = 1'b0;
      at_t[n] = t; at_v[n] = v; at_r[n] = "R2"; n++;
      t += 10*C + 1; v[9] = 1'b0;
      at_t[n] = t; at_v[n] = v; at_r[n] = "R2"; n++;
      for (int k = 0; k < 5; k++) begin
        t += (k == 0) ? 1 : exp_dwell(k-1)*C + 1;
        v[8:1] = exp_code(k);
        at_t[n] = t; at_v[n] = v; at_r[n] = "R3"; n++;
      end
      if (stall) begin tr = t + 20*C + extra; t = tr + 2; end
      else t = t + 20*C + 2;
      v[0] = 1'b0; at_t[n] = t; at_v[n] = v; at_r[n] = "R4"; n++;
      t += 20*C + 1; v[12:11] = 2'b11; at_t[n] = t; at_v[n] = v; at_r[n] = "R4"; n++;
      t += 1; v[9] = 1'b1; at_t[n] = t; at_v[n] = v; at_r[n] = "R4"; n++;
      done_t = t;
    end else begin
      v[12:11] = 2'b00; at_t[n] = 2; at_v[n] = v; at_r[n] = "R5"; n++;
      v[9] = 1'b0;      at_t[n] = 3; at_v[n] = v; at_r[n] = "R5"; n++;
      v[0] = 1'b1;      at_t[n] = 4; at_v[n] = v; at_r[n] = "R5"; n++;
      s = 4 + 20*C + 1; v[8:1] = 8'hFF; at_t[n] = s; at_v[n] = v; at_r[n] = "R5"; n++;
      if (stall) begin tr = s + 30*C + extra; done_t = tr + 1; end
      else done_t = s + 30*C + 1;
    end
    if (stall && n > 0) begin hold = 1; hc = c; end
    tick();
    req_valid = 1'b1; req_up = up; req_core = 2'(c);
    for (t = 1; t <= done_t + 2; t++) begin
      if (t == tr) hold = 0;
      tick();
      if (t == 1) req_valid = 1'b0;
      cur = mv[c]; rq = (n == 0) ? "R8" : "R10";
      for (int a = 0; a < n; a++) if (at_t[a] <= t) begin cur = at_v[a]; rq = at_r[a]; end
      chk(vec_of(c) == cur, rq, $sformatf("core %0d outputs t=%0d", c, t), 32'(vec_of(c)), 32'(cur));
      for (int o = 0; o < N; o++) if (o != c)
        chk(vec_of(o) == mv[o], spur ? "R7" : "R11", $sformatf("other core %0d t=%0d", o, t),
            32'(vec_of(o)), 32'(mv[o]));
      chk(busy == (n > 0 && t < done_t), (n == 0) ? "R8" : "R10", $sformatf("busy t=%0d", t),
          32'(busy), 32'(n > 0 && t < done_t));
      chk(done == (t == done_t), (n == 0) ? "R8" : ((stall && !up) ? "R6" : "R10"),
          $sformatf("done t=%0d", t), 32'(done), 32'(t == done_t));
      if (spur && n > 0 && t == 5) begin
        req_valid = 1'b1; req_up = 1'($urandom); req_core = 2'((c + 1 + $urandom % 3) % 4);
      end
      if (t == 6) req_valid = 1'b0;
    end
    hold = 0;
    if (n > 0) mv[c] = at_v[n-1];
    mon[c] = up;
  endtask

  task automatic bad_req(input logic [1:0] cfg, input int c);
    cfg_cores = cfg;
    tick();
    req_valid = 1'b1; req_up = 1'b1; req_core = 2'(c);
    tick();
    req_valid = 1'b0;
    for (int t = 0; t < 6; t++) begin
      tick();
      chk(!busy && !done, "R7", "out-of-range request", {busy, done}, 32'd0);
      for (int o = 0; o < N; o++)
        chk(vec_of(o) == mv[o], "R7", $sformatf("core %0d after bad index", o), 32'(vec_of(o)), 32'(mv[o]));
    end
    cfg_cores = 2'd3;
  endtask

  initial begin
    void'($urandom(32'h5EC0_0007));
    for (int c = 0; c < N; c++) begin mv[c] = {2'b00, 1'b1, 1'b0, 8'hFF, 1'b1}; mon[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    for (int c = 0; c < N; c++)
      chk(vec_of(c) == mv[c], "R1", $sformatf("reset core %0d", c), 32'(vec_of(c)), 32'(mv[c]));
    chk(!busy && !done, "R1", "reset flags", {busy, done}, 32'd0);

    run(0, 1, 0, 0, 0);
    run(0, 1, 0, 0, 0);
    run(3, 0, 0, 0, 0);
    run(3, 1, 1, 1, 0);
    run(0, 0, 1, 1, 0);
    run(1, 1, 0, 0, 1);
    run(1, 0, 1, 7, 1);
    bad_req(2'd1, 2);
    bad_req(2'd0, 1);
    for (int i = 0; i < 40; i++)
      run($urandom % 4, 1'($urandom), 1'($urandom), 1 + $urandom % 5, 1'($urandom));

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!fin) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule